// File: doc/BRIEF.md
# Interrupting Serial Port with Shared-Address Registers

This block is a bus-attached asynchronous serial port for a small processor. It sends and receives 8-bit frames made of one start bit, eight data bits sent least significant bit first, and one stop bit. Software sees only two word locations, and each location has two meanings. At the first location, a write sets up the port: the rate and the two interrupt enables. A read at the same location returns the flags. At the second location, a write hands a byte to the transmitter and a read takes the last byte that was received.

The bit period is `BASE_DIV << speed` system clocks, where `speed` is a 3-bit code. The transmitter has no holding buffer: one byte at a time goes straight into its shift register. The receiver looks for a falling edge on the line. It checks the start bit half a bit period later, then samples each following bit one full bit period after the previous sample. A single level interrupt request is the OR of two pending conditions, transmitter empty and byte received, each gated by its own enable.

Top module: `serport_mmio`

## Requirements
- R1: After reset the status word reads 0x00000040 (only transmitter-empty set), the serial output is high and the interrupt request is low.
- R2: Bus address bit `bus_addr_i`=0 selects control on write and status on read; `bus_addr_i`=1 selects transmit data on write and received data on read. Bits 31..8 are ignored on write and always read as zero.
- R3: A data write while the transmitter is empty sends a start bit (0), then the byte least significant bit first, then a stop bit (1). Each bit lasts `BASE_DIV << ctrl[2:0]` clocks, with the default BASE_DIV=4.
- R4: A data write clears status bit 6 (transmitter empty) until the stop bit has been sent. A data write made while bit 6 is clear is ignored.
- R5: A correctly framed incoming byte sets status bit 5 (byte available). Reading the data location returns the byte in bits 7..0 and clears bit 5. The receiver needs a bit period of at least 8 clocks.
- R6: Status bit 0 (overrun) is set when a byte completes while bit 5 is still set. The newer byte replaces the older one.
- R7: Status bit 1 (framing error) is set when the stop bit samples low. The byte is still delivered.
- R8: A status read clears bits 1 and 0. If the same edge also sets a flag, setting wins.
- R9: Control bit 3 enables the receive interrupt and control bit 4 enables the transmit interrupt. Status bit 3 equals bit 5 AND the receive enable. Status bit 4 equals bit 6 AND the transmit enable. `irq_o` is the OR of status bits 3 and 4.
- R10: Status bits 7 and 2 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | Address bit 2: 0 = control/status, 1 = data |
| bus_wdata_i | input | DATA_W | Write data; only bits 7..0 are used |
| bus_rdata_o | output | DATA_W | Read data, valid in the cycle of a read strobe |
| ser_rx_i | input | 1 | Serial input line |
| ser_tx_o | output | 1 | Serial output line, high when idle |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two situations are hard to reach from the ports.

The first is an overrun. The bench must drive two complete frames onto the serial input with no data read between them, so that the second stop bit arrives while the first byte is still unread. It must then read status twice: the first read shows the sticky overrun flag, and the second read shows that the first read cleared it.

The second is the write that arrives while the transmitter is busy. The bench issues a second data write a few cycles after the first, then decodes every frame on the serial output against a scoreboard queue. The ignored byte must never appear on the line.

// File: rtl/serport_pkg.sv
package serport_pkg;
   localparam int SPEED_W     = 3;
   localparam int CTL_EN_RX   = 3;
   localparam int CTL_EN_TX   = 4;
   localparam int CTL_W       = 5;
   localparam int ST_OVERRUN  = 0;
   localparam int ST_FRAMING  = 1;
   localparam int ST_PEND_RX  = 3;
   localparam int ST_PEND_TX  = 4;
   localparam int ST_RX_FULL  = 5;
   localparam int ST_TX_EMPTY = 6;
   localparam int FRAME_BITS  = 10;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_HOLD
   } rx_state_e;
endpackage

// File: rtl/serport_sync.sv
module serport_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 0) begin : g_bad_stages
      $error("serport_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else if (STAGES == 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) r_q <= 1'b1;
         else         r_q <= d_i;
      end
      assign q_o = r_q;
   end else begin : g_chain
      logic [STAGES-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) r_q <= '1;
         else         r_q <= {r_q[STAGES-2:0], d_i};
      end
      assign q_o = r_q[STAGES-1];
   end
endmodule

// File: rtl/serport_tx.sv
module serport_tx import serport_pkg::*; #(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [7:0]       byte_i,
   input  logic [CNT_W-1:0] div_i,
   output logic             ser_o,
   output logic             done_o
);
   logic [FRAME_BITS-1:0] sh_q;
   logic [3:0]            bits_q;
   logic [CNT_W-1:0]      cnt_q;
   logic                  busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '1;
         bits_q <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !busy_q) begin
            sh_q   <= {1'b1, byte_i, 1'b0};
            bits_q <= 4'(FRAME_BITS - 1);
            cnt_q  <= div_i - 1'b1;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (cnt_q == '0) begin
               if (bits_q == '0) begin
                  busy_q <= 1'b0;
                  done_o <= 1'b1;
                  sh_q   <= '1;
               end else begin
                  sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
                  bits_q <= bits_q - 1'b1;
                  cnt_q  <= div_i - 1'b1;
               end
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign ser_o = sh_q[0];
endmodule

// File: rtl/serport_rx.sv
module serport_rx import serport_pkg::*; #(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             line_i,
   input  logic [CNT_W-1:0] div_i,
   output logic [7:0]       byte_o,
   output logic             done_o,
   output logic             bad_stop_o
);
   rx_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [2:0]       idx_q;
   logic [7:0]       sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q       <= RX_IDLE;
         cnt_q      <= '0;
         idx_q      <= '0;
         sh_q       <= '0;
         done_o     <= 1'b0;
         bad_stop_o <= 1'b0;
      end else begin
         done_o     <= 1'b0;
         bad_stop_o <= 1'b0;
         unique case (st_q)
            RX_IDLE: if (!line_i) begin
               cnt_q <= (div_i >> 1) - 1'b1;
               st_q  <= RX_START;
            end
            RX_START: if (cnt_q == '0) begin
               if (!line_i) begin
                  cnt_q <= div_i - 1'b1;
                  idx_q <= '0;
                  st_q  <= RX_DATA;
               end else begin
                  st_q  <= RX_IDLE;
               end
            end else cnt_q <= cnt_q - 1'b1;
            RX_DATA: if (cnt_q == '0) begin
               sh_q  <= {line_i, sh_q[7:1]};
               cnt_q <= div_i - 1'b1;
               if (idx_q == 3'd7) st_q <= RX_STOP;
               else               idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
            RX_STOP: if (cnt_q == '0) begin
               done_o     <= 1'b1;
               bad_stop_o <= !line_i;
               st_q       <= RX_HOLD;
            end else cnt_q <= cnt_q - 1'b1;
            RX_HOLD: if (line_i) st_q <= RX_IDLE;
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   assign byte_o = sh_q;
endmodule

// File: rtl/serport_mmio.sv
module serport_mmio import serport_pkg::*; #(
   parameter int DATA_W      = 32,
   parameter int BASE_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic              bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              ser_rx_i,
   output logic              ser_tx_o,
   output logic              irq_o
);
   localparam int MAX_DIV = BASE_DIV << ((1 << SPEED_W) - 1);
   localparam int CNT_W   = $clog2(MAX_DIV) + 1;

   if (DATA_W < 8) begin : g_bad_width
      $error("serport_mmio: DATA_W must be at least 8");
   end
   if (BASE_DIV < 4 || (BASE_DIV % 2) != 0) begin : g_bad_div
      $error("serport_mmio: BASE_DIV must be even and at least 4");
   end

   logic [CTL_W-1:0] ctrl_q;
   logic             tx_empty_q, rx_full_q, ferr_q, oerr_q;
   logic [7:0]       rx_byte_q;
   logic [CNT_W-1:0] div;
   logic             wr_ctl, wr_dat, rd_st, rd_dat;
   logic             tx_done, rx_done, rx_bad, rx_line;
   logic [7:0]       rx_data;
   logic             pend_tx, pend_rx;
   logic             unused_hi;

   assign unused_hi = ^bus_wdata_i[DATA_W-1:8];
   assign wr_ctl = bus_sel_i &&  bus_wr_i && !bus_addr_i;
   assign wr_dat = bus_sel_i &&  bus_wr_i &&  bus_addr_i;
   assign rd_st  = bus_sel_i && !bus_wr_i && !bus_addr_i;
   assign rd_dat = bus_sel_i && !bus_wr_i &&  bus_addr_i;
   assign div    = CNT_W'(BASE_DIV) << ctrl_q[SPEED_W-1:0];

   serport_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ser_rx_i), .q_o(rx_line));

   serport_tx #(.CNT_W(CNT_W)) u_tx (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(wr_dat && tx_empty_q),
      .byte_i(bus_wdata_i[7:0]), .div_i(div), .ser_o(ser_tx_o), .done_o(tx_done));

   serport_rx #(.CNT_W(CNT_W)) u_rx (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(rx_line), .div_i(div),
      .byte_o(rx_data), .done_o(rx_done), .bad_stop_o(rx_bad));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q     <= '0;
         tx_empty_q <= 1'b1;
         rx_full_q  <= 1'b0;
         rx_byte_q  <= '0;
         ferr_q     <= 1'b0;
         oerr_q     <= 1'b0;
      end else begin
         if (wr_ctl) ctrl_q <= bus_wdata_i[CTL_W-1:0];

         if (wr_dat && tx_empty_q) tx_empty_q <= 1'b0;
         else if (tx_done)         tx_empty_q <= 1'b1;

         if (rx_done)     rx_full_q <= 1'b1;
         else if (rd_dat) rx_full_q <= 1'b0;

         if (rx_done) rx_byte_q <= rx_data;

         if (rx_done && rx_full_q) oerr_q <= 1'b1;
         else if (rd_st)           oerr_q <= 1'b0;

         if (rx_done && rx_bad) ferr_q <= 1'b1;
         else if (rd_st)        ferr_q <= 1'b0;
      end
   end

   assign pend_tx = tx_empty_q && ctrl_q[CTL_EN_TX];
   assign pend_rx = rx_full_q  && ctrl_q[CTL_EN_RX];
   assign irq_o   = pend_tx || pend_rx;

   always_comb begin
      bus_rdata_o = '0;
      if (rd_dat) begin
         bus_rdata_o[7:0] = rx_byte_q;
      end else if (rd_st) begin
         bus_rdata_o[ST_TX_EMPTY] = tx_empty_q;
         bus_rdata_o[ST_RX_FULL]  = rx_full_q;
         bus_rdata_o[ST_PEND_TX]  = pend_tx;
         bus_rdata_o[ST_PEND_RX]  = pend_rx;
         bus_rdata_o[ST_FRAMING]  = ferr_q;
         bus_rdata_o[ST_OVERRUN]  = oerr_q;
      end
   end
endmodule

// File: rtl/serport_mmio_chk.sv
module serport_mmio_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bus_sel_i,
   input logic              bus_wr_i,
   input logic              bus_addr_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              ser_tx_o,
   input logic              irq_o,
   input logic              tx_empty_q,
   input logic              rx_full_q,
   input logic              oerr_q,
   input logic              rx_done,
   input logic [4:0]        ctrl_q
);
   AST_TX_LINE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_empty_q |-> ser_tx_o); // R4
   AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && bus_wr_i && bus_addr_i && tx_empty_q) |=> !tx_empty_q); // R4
   AST_DONE_SETS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_done |=> rx_full_q); // R5
   AST_READ_CLEARS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && !bus_wr_i && bus_addr_i && !rx_done) |=> !rx_full_q); // R5
   AST_OVERRUN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_done && rx_full_q) |=> oerr_q); // R6
   AST_NO_IRQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[4:3] == 2'b00) |-> !irq_o); // R9
   AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_sel_i |-> (bus_rdata_o[DATA_W-1:8] == '0)); // R2
   AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && !bus_wr_i && !bus_addr_i) |-> (!bus_rdata_o[7] && !bus_rdata_o[2])); // R10
endmodule

bind serport_mmio serport_mmio_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
   .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .ser_tx_o(ser_tx_o),
   .irq_o(irq_o), .tx_empty_q(tx_empty_q), .rx_full_q(rx_full_q),
   .oerr_q(oerr_q), .rx_done(rx_done), .ctrl_q(ctrl_q));

// File: tb/serport_mmio_tb_top.sv
module serport_mmio_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0, addr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ser_rx = 1'b1;
   logic        ser_tx, irq;
   int          vectors = 0, miscompares = 0;
   int          cur_div = 4;
   logic [7:0]  sb_q[$];

   always #2 clk = ~clk;

   serport_mmio dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .ser_rx_i(ser_rx), .ser_tx_o(ser_tx), .irq_o(irq));

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic a, input logic [31:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); sel = 1'b0; wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic a, output logic [31:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk); sel = 1'b0;
   endtask

   task automatic set_ctrl(input logic [31:0] v);
      cur_div = 4 << v[2:0];
      bus_write(1'b0, v);
   endtask

   task automatic tx_send(input logic [7:0] b);
      sb_q.push_back(b);
      bus_write(1'b1, {24'hABCDEF, b});
   endtask

   task automatic wait_frame();
      repeat (11 * cur_div + 6) @(negedge clk);
   endtask

   task automatic rx_frame(input logic [7:0] b, input logic stop_bit);
      @(negedge clk); ser_rx = 1'b0;
      repeat (cur_div) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         ser_rx = b[i];
         repeat (cur_div) @(negedge clk);
      end
      ser_rx = stop_bit;
      repeat (cur_div) @(negedge clk);
      ser_rx = 1'b1;
      repeat (cur_div) @(negedge clk);
   endtask

   // monitor: decodes frames on ser_tx and compares with scoreboard (R3)
   initial begin
      forever begin
         logic [7:0] got;
         int d;
         @(negedge ser_tx);
         d = cur_div;
         repeat (d / 2) @(posedge clk);
         #1 check("R3 start bit", {31'd0, ser_tx}, 32'd0);
         for (int i = 0; i < 8; i++) begin
            repeat (d) @(posedge clk);
            #1 got[i] = ser_tx;
         end
         repeat (d) @(posedge clk);
         #1 check("R3 stop bit", {31'd0, ser_tx}, 32'd1);
         if (sb_q.size() == 0) begin
            check("R4 unexpected frame", {24'd0, got}, 32'hFFFF_FFFF);
         end else begin
            check("R3 frame byte", {24'd0, got}, {24'd0, sb_q.pop_front()});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(1'b0, r);
      check("R1 status after reset", r, 32'h40);
      check("R1 tx line idle", {31'd0, ser_tx}, 32'd1);
      check("R1 irq low", {31'd0, irq}, 32'd0);

      // R2 upper write bits ignored: bit 8 set, enables clear -> no irq
      set_ctrl(32'hFFFF_FF00);
      check("R2 upper ctrl bits ignored", {31'd0, irq}, 32'd0);
      bus_read(1'b1, r);
      check("R2 data read upper zero", r, 32'h0);

      // R3 at fastest rate, then slower rate
      set_ctrl(32'h0);
      tx_send(8'hA5);
      wait_frame();
      set_ctrl(32'h3);
      tx_send(8'h3C);
      wait_frame();

      // R4 write while busy is ignored
      set_ctrl(32'h0);
      tx_send(8'h55);
      bus_read(1'b0, r);
      check("R4 tx empty cleared", r, 32'h00);
      bus_write(1'b1, 32'h99);
      wait_frame();
      wait_frame();
      check("R4 scoreboard drained", sb_q.size(), 32'd0);
      bus_read(1'b0, r);
      check("R4 tx empty restored", r, 32'h40);

      // R5 reception at speed 2
      set_ctrl(32'h2);
      rx_frame(8'h5A, 1'b1);
      bus_read(1'b0, r);
      check("R5 R10 rx full status", r, 32'h60);
      bus_read(1'b1, r);
      check("R5 rx byte", r, 32'h5A);
      bus_read(1'b0, r);
      check("R5 rx full cleared", r, 32'h40);

      // R6 overrun, R8 clear on status read
      rx_frame(8'h11, 1'b1);
      rx_frame(8'h22, 1'b1);
      bus_read(1'b0, r);
      check("R6 overrun flag", r, 32'h61);
      bus_read(1'b0, r);
      check("R8 overrun cleared by read", r, 32'h60);
      bus_read(1'b1, r);
      check("R6 newer byte kept", r, 32'h22);

      // R7 framing error, R8
      rx_frame(8'h33, 1'b0);
      bus_read(1'b0, r);
      check("R7 framing flag", r, 32'h62);
      bus_read(1'b0, r);
      check("R8 framing cleared by read", r, 32'h60);
      bus_read(1'b1, r);
      check("R7 byte delivered", r, 32'h33);

      // R9 interrupts
      set_ctrl(32'h0A);
      check("R9 rx enable alone no irq", {31'd0, irq}, 32'd0);
      rx_frame(8'h44, 1'b1);
      check("R9 rx irq raised", {31'd0, irq}, 32'd1);
      bus_read(1'b0, r);
      check("R9 R10 rx pending status", r, 32'h68);
      bus_read(1'b1, r);
      check("R9 rx irq data", r, 32'h44);
      check("R9 rx irq cleared", {31'd0, irq}, 32'd0);
      set_ctrl(32'h12);
      check("R9 tx irq raised", {31'd0, irq}, 32'd1);
      bus_read(1'b0, r);
      check("R9 tx pending status", r, 32'h50);
      tx_send(8'h81);
      check("R9 tx irq dropped on write", {31'd0, irq}, 32'd0);
      wait_frame();
      check("R9 tx irq back after frame", {31'd0, irq}, 32'd1);
      check("R3 all frames seen", sb_q.size(), 32'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule